// File: doc/BRIEF.md
# Path Trace Identifier Monitor

This block watches a trace identifier that arrives one byte per frame in an overhead slot and reports whether it matches what is expected. An upstream stage supplies the byte with a valid strobe that already marks the trace slot. Software loads the expected identifier into internal storage through a small register port, where it can also read it back. The monitor finds where each repeating string starts, compares every received byte with the stored byte at the same position and raises a trace mismatch alarm when any byte differs.

Two string lengths are supported. In the 16-byte length, a marker byte with its top bit set opens each string and carries a CRC-7 of the string. The block computes that CRC itself and raises a separate CRC alarm when the two disagree. In the 64-byte length, the string is delimited by a carriage return followed by a line feed, and no CRC is checked. Each alarm is decided once per complete string and keeps its value until the next complete string is judged.

Top module: `trace_id_monitor`

## Requirements
- R1: While rst_n is low, both alarms are 0 and every location of expected storage reads back as 0.
- R2: A cycle with reg_wr_en high stores reg_wdata at location reg_addr. reg_rdata always shows the stored byte at reg_addr in the same cycle, with no clock delay.
- R3: With mode_long low, a valid byte whose bit 7 is 1 is position 0. It and the next 15 valid bytes form one string. The alarms change only at the clock edge that accepts the 16th byte. Bytes with trc_vld low are ignored, and bytes with bit 7 at 0 are ignored while no string is open.
- R4: At each string evaluation, alm_trace becomes 1 if any received byte differs from the stored byte at the same position, and 0 if all match. Between evaluations it holds its value.
- R5: Until at least one register write has happened since reset, every evaluation leaves alm_trace at 0.
- R6: With mode_long low, the CRC is the remainder of (string bits, first byte first, most significant bit first, with bits 6..0 of the position-0 byte taken as 0) times x^7, divided by x^7 + x^3 + 1. At each evaluation, alm_crc becomes 1 if this value differs from bits 6..0 of the position-0 byte, and 0 otherwise.
- R7: With mode_long high, a byte 0x0D followed by a byte 0x0A marks the end of a string, and the next valid byte is position 0. A string is evaluated when its byte at position 62 is 0x0D and its byte at position 63 is 0x0A. The comparison then covers all 64 positions.
- R8: At every clock edge where mode_long is high, alm_crc is cleared to 0.
- R9: An unfinished string never causes an evaluation. In the 16-byte length, a marker byte that arrives before position 15 starts a new string. In the 64-byte length, a 0x0D 0x0A pair that ends before position 63 starts a new string at the following byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| trc_byte | input | 8 | Received trace byte |
| trc_vld | input | 1 | Marks a cycle that carries a trace byte |
| mode_long | input | 1 | 0: 16-byte strings with CRC-7; 1: 64-byte strings |
| reg_wr_en | input | 1 | Write strobe for expected storage |
| reg_addr | input | 6 | Storage location for write and read |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Stored byte at reg_addr |
| alm_trace | output | 1 | Trace mismatch alarm |
| alm_crc | output | 1 | CRC-7 mismatch alarm |

## Verification
The hardest case to reach from the ports is a string that restarts before it finishes. The bench must show that the earlier fragment leaves no trace in the next verdict and that no verdict falls at the wrong byte count. To set this up, the bench first forces an alarm into a known state with a complete string. It then sends a fragment that is cut short by a new marker or by an early carriage-return/line-feed pair, followed by a clean string. It samples the alarm at the byte where a design that failed to restart would have issued a verdict, and again at the true end of the string. The CRC-only failure is reached the same way: the stored first byte is rewritten to match a corrupted marker byte, so that the trace comparison passes while the CRC check fails.

// File: rtl/tim_pkg.sv
package tim_pkg;
   localparam logic [7:0] CHR_CR = 8'h0D;
   localparam logic [7:0] CHR_LF = 8'h0A;

   typedef enum logic {
      LEN_SHORT = 1'b0,
      LEN_LONG  = 1'b1
   } len_mode_e;
endpackage

// File: rtl/tim_exp_store.sv
module tim_exp_store #(
   parameter int DEPTH  = 64,
   parameter int DATA_W = 8,
   parameter int ADDR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] host_rdata,
   input  logic [ADDR_W-1:0] cmp_addr,
   output logic [DATA_W-1:0] cmp_data,
   output logic              written
);
   logic [DATA_W-1:0] mem_q [DEPTH];
   logic              written_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
         written_q <= 1'b0;
      end else if (wr_en) begin
         mem_q[host_addr] <= wr_data;
         written_q        <= 1'b1;
      end
   end

   assign host_rdata = mem_q[host_addr];
   assign cmp_data   = mem_q[cmp_addr];
   assign written    = written_q;
endmodule

// File: rtl/tim_align.sv
module tim_align #(
   parameter int SHORT_LEN = 16,
   parameter int LONG_LEN  = 64,
   parameter int DATA_W    = 8,
   parameter int POS_W     = $clog2(LONG_LEN)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vld,
   input  logic [DATA_W-1:0] din,
   input  logic              mode_long,
   output logic              acc_en,
   output logic              acc_first,
   output logic              acc_last,
   output logic [POS_W-1:0]  acc_idx
);
   import tim_pkg::*;

   localparam logic [POS_W-1:0] SHORT_END = POS_W'(SHORT_LEN - 1);
   localparam logic [POS_W-1:0] LONG_END  = POS_W'(LONG_LEN - 1);

   logic              sync_q, sync_d;
   logic [POS_W-1:0]  pos_q, pos_d;
   logic [DATA_W-1:0] prev_q;
   logic              mode_q;
   logic              mode_chg, live, crlf, marker;

   always_comb begin
      mode_chg  = (mode_long != mode_q);
      live      = sync_q & ~mode_chg;
      crlf      = (prev_q == DATA_W'(CHR_CR)) && (din == DATA_W'(CHR_LF));
      marker    = din[DATA_W-1];
      acc_en    = 1'b0;
      acc_first = 1'b0;
      acc_last  = 1'b0;
      acc_idx   = pos_q;
      sync_d    = live;
      pos_d     = pos_q;
      if (vld) begin
         if (mode_long == LEN_SHORT) begin
            if (marker) begin
               acc_en    = 1'b1;
               acc_first = 1'b1;
               acc_idx   = '0;
               sync_d    = 1'b1;
               pos_d     = POS_W'(1);
            end else if (live) begin
               acc_en   = 1'b1;
               acc_last = (pos_q == SHORT_END);
               pos_d    = pos_q + POS_W'(1);
               if (acc_last) sync_d = 1'b0;
            end
         end else begin
            if (live) begin
               acc_en    = 1'b1;
               acc_first = (pos_q == '0);
               if (pos_q == LONG_END) begin
                  if (crlf) begin
                     acc_last = 1'b1;
                     pos_d    = '0;
                  end else begin
                     sync_d = 1'b0;
                  end
               end else if (crlf) begin
                  pos_d = '0;
               end else begin
                  pos_d = pos_q + POS_W'(1);
               end
            end else if (crlf) begin
               sync_d = 1'b1;
               pos_d  = '0;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= 1'b0;
         pos_q  <= '0;
         prev_q <= '0;
         mode_q <= 1'b0;
      end else begin
         sync_q <= sync_d;
         pos_q  <= pos_d;
         mode_q <= mode_long;
         if (vld) prev_q <= din;
      end
   end
endmodule

// File: rtl/tim_crc7.sv
module tim_crc7 #(
   parameter int               DATA_W = 8,
   parameter int               CRC_W  = 7,
   parameter logic [CRC_W-1:0] POLY   = 7'h09
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              first,
   input  logic [DATA_W-1:0] din,
   output logic [CRC_W-1:0]  crc_nxt
);
   logic [CRC_W-1:0]             crc_q;
   logic [DATA_W:0][CRC_W-1:0]   stage;
   logic [DATA_W-1:0]            feed;

   assign feed     = first ? {din[DATA_W-1], {(DATA_W-1){1'b0}}} : din;
   assign stage[0] = first ? '0 : crc_q;

   for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      logic fb;
      assign fb         = stage[b][CRC_W-1] ^ feed[DATA_W-1-b];
      assign stage[b+1] = {stage[b][CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
   end

   assign crc_nxt = stage[DATA_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  crc_q <= '0;
      else if (en) crc_q <= crc_nxt;
   end
endmodule

// File: rtl/trace_id_monitor.sv
module trace_id_monitor #(
   parameter int               DATA_W    = 8,
   parameter int               SHORT_LEN = 16,
   parameter int               LONG_LEN  = 64,
   parameter int               CRC_W     = 7,
   parameter logic [CRC_W-1:0] CRC_POLY  = 7'h09,
   parameter bit               CRC_EN    = 1'b1,
   parameter int               ADDR_W    = $clog2(LONG_LEN)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] trc_byte,
   input  logic              trc_vld,
   input  logic              mode_long,
   input  logic              reg_wr_en,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              alm_trace,
   output logic              alm_crc
);
   if (DATA_W != 8) begin : g_bad_width
      $error("trace_id_monitor: delimiter detection needs 8-bit bytes");
   end
   if (SHORT_LEN < 2 || SHORT_LEN > LONG_LEN) begin : g_bad_len
      $error("trace_id_monitor: SHORT_LEN must lie in 2..LONG_LEN");
   end
   if (CRC_W != DATA_W - 1) begin : g_bad_crc
      $error("trace_id_monitor: CRC field must fill the marker byte below its flag");
   end
   if ((1 << ADDR_W) < LONG_LEN) begin : g_bad_addr
      $error("trace_id_monitor: ADDR_W too narrow for LONG_LEN");
   end

   logic              acc_en, acc_first, acc_last;
   logic [ADDR_W-1:0] acc_idx;
   logic [DATA_W-1:0] exp_byte;
   logic              exp_written;
   logic              mm_q, mm_cur;

   tim_exp_store #(.DEPTH(LONG_LEN), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (reg_wr_en),
      .host_addr (reg_addr),
      .wr_data   (reg_wdata),
      .host_rdata(reg_rdata),
      .cmp_addr  (acc_idx),
      .cmp_data  (exp_byte),
      .written   (exp_written)
   );

   tim_align #(.SHORT_LEN(SHORT_LEN), .LONG_LEN(LONG_LEN), .DATA_W(DATA_W), .POS_W(ADDR_W)) i_align (
      .clk      (clk),
      .rst_n    (rst_n),
      .vld      (trc_vld),
      .din      (trc_byte),
      .mode_long(mode_long),
      .acc_en   (acc_en),
      .acc_first(acc_first),
      .acc_last (acc_last),
      .acc_idx  (acc_idx)
   );

   assign mm_cur = (acc_first ? 1'b0 : mm_q) | (trc_byte != exp_byte);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mm_q      <= 1'b0;
         alm_trace <= 1'b0;
      end else if (acc_en) begin
         mm_q <= mm_cur;
         if (acc_last) alm_trace <= mm_cur & exp_written;
      end
   end

   if (CRC_EN) begin : g_crc
      logic [CRC_W-1:0] crc_calc;
      logic [CRC_W-1:0] rx_field_q;

      tim_crc7 #(.DATA_W(DATA_W), .CRC_W(CRC_W), .POLY(CRC_POLY)) i_crc (
         .clk    (clk),
         .rst_n  (rst_n),
         .en     (acc_en & ~mode_long),
         .first  (acc_first),
         .din    (trc_byte),
         .crc_nxt(crc_calc)
      );

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rx_field_q <= '0;
            alm_crc    <= 1'b0;
         end else if (mode_long) begin
            alm_crc <= 1'b0;
         end else if (acc_en) begin
            if (acc_first) rx_field_q <= trc_byte[CRC_W-1:0];
            if (acc_last)  alm_crc    <= (crc_calc != rx_field_q);
         end
      end
   end else begin : g_no_crc
      assign alm_crc = 1'b0;
   end
endmodule

// File: rtl/tim_monitor_chk.sv
module tim_monitor_chk #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              trc_vld,
   input logic              mode_long,
   input logic              reg_wr_en,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [DATA_W-1:0] reg_wdata,
   input logic [DATA_W-1:0] reg_rdata,
   input logic              alm_trace,
   input logic              alm_crc
);
   logic seen_wr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         seen_wr <= 1'b0;
      else if (reg_wr_en) seen_wr <= 1'b1;
   end

   p_rdata_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr_en |=> (reg_addr != $past(reg_addr)) || (reg_rdata == $past(reg_wdata)));

   p_trace_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !trc_vld |=> $stable(alm_trace));

   p_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !seen_wr |-> !alm_trace);

   p_crc_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!trc_vld && !mode_long) |=> $stable(alm_crc));

   p_crc_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      mode_long |=> !alm_crc);
endmodule

bind trace_id_monitor tim_monitor_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .trc_vld  (trc_vld),
   .mode_long(mode_long),
   .reg_wr_en(reg_wr_en),
   .reg_addr (reg_addr),
   .reg_wdata(reg_wdata),
   .reg_rdata(reg_rdata),
   .alm_trace(alm_trace),
   .alm_crc  (alm_crc)
);

// File: tb/test_trace_id_monitor.sv
module test_trace_id_monitor;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n;
   logic [7:0] trc_byte;
   logic       trc_vld;
   logic       mode_long;
   logic       reg_wr_en;
   logic [5:0] reg_addr;
   logic [7:0] reg_wdata;
   logic [7:0] reg_rdata;
   logic       alm_trace;
   logic       alm_crc;

   int checks = 0;
   int errors = 0;

   logic [7:0] s_ok  [16];
   logic [7:0] s_bad [16];
   logic [7:0] s_crc [16];
   logic [7:0] l_ok  [64];
   logic [7:0] l_bad [64];

   always #(CLK_PERIOD/2) clk = ~clk;

   trace_id_monitor i_trace_id_monitor (
      .clk(clk), .rst_n(rst_n), .trc_byte(trc_byte), .trc_vld(trc_vld),
      .mode_long(mode_long), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .alm_trace(alm_trace), .alm_crc(alm_crc)
   );

   function automatic logic [6:0] ref_crc(input logic [7:0] s [16]);
      logic [134:0] v;
      v = '0;
      for (int i = 0; i < 16; i++)
         v[134-8*i -: 8] = (i == 0) ? {s[0][7], 7'b0} : s[i];
      for (int k = 134; k >= 7; k--)
         if (v[k]) v[k -: 8] = v[k -: 8] ^ 8'h89;
      return v[6:0];
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic send_byte(input logic [7:0] b, input int gap);
      trc_vld  = 1'b1;
      trc_byte = b;
      @(negedge clk);
      trc_vld  = 1'b0;
      for (int g = 0; g < gap; g++) @(negedge clk);
   endtask

   task automatic send16(input logic [7:0] s [16], input int from, input int upto);
      for (int i = from; i <= upto; i++) send_byte(s[i], 0);
   endtask

   task automatic send64(input logic [7:0] s [64], input int from, input int upto);
      for (int i = from; i <= upto; i++) send_byte(s[i], 0);
   endtask

   task automatic write_exp(input int addr, input logic [7:0] d);
      reg_wr_en = 1'b1;
      reg_addr  = 6'(addr);
      reg_wdata = d;
      @(negedge clk);
      reg_wr_en = 1'b0;
   endtask

   task automatic t_reset;
      reg_addr = 6'd0;  #1 check("R1 rdata addr 0", reg_rdata, 8'h00);
      reg_addr = 6'd63; #1 check("R1 rdata addr 63", reg_rdata, 8'h00);
      check("R1 alm_trace in reset", alm_trace, 1'b0);
      check("R1 alm_crc in reset", alm_crc, 1'b0);
   endtask

   task automatic t_mask;
      send16(s_ok, 0, 15);
      check("R5 trace masked before any write", alm_trace, 1'b0);
      check("R6 crc ok on valid string", alm_crc, 1'b0);
   endtask

   task automatic t_regs;
      for (int i = 0; i < 16; i++) write_exp(i, s_ok[i]);
      reg_addr = 6'd0;  #1 check("R2 readback addr 0", reg_rdata, s_ok[0]);
      reg_addr = 6'd15; #1 check("R2 readback addr 15", reg_rdata, s_ok[15]);
      reg_addr = 6'd40; #1 check("R2 untouched addr 40", reg_rdata, 8'h00);
   endtask

   task automatic t_match16;
      send16(s_ok, 0, 15);
      check("R4 trace clear on match", alm_trace, 1'b0);
      check("R6 crc clear on match", alm_crc, 1'b0);
   endtask

   task automatic t_diff16;
      send16(s_bad, 0, 15);
      check("R4 trace set on one differing byte", alm_trace, 1'b1);
      repeat (5) @(negedge clk);
      check("R4 trace held while idle", alm_trace, 1'b1);
      send16(s_ok, 0, 15);
      check("R4 trace cleared by good string", alm_trace, 1'b0);
   endtask

   task automatic t_crc_only;
      write_exp(0, s_crc[0]);
      send16(s_crc, 0, 15);
      check("R6 crc alarm on wrong field", alm_crc, 1'b1);
      check("R6 trace clean while crc wrong", alm_trace, 1'b0);
      write_exp(0, s_ok[0]);
      send16(s_ok, 0, 15);
      check("R6 crc alarm cleared", alm_crc, 1'b0);
   endtask

   task automatic t_window;
      send16(s_bad, 0, 15);
      send_byte(8'h11, 0);
      send_byte(8'h22, 1);
      send_byte(8'h33, 0);
      for (int i = 0; i < 15; i++) send_byte(s_ok[i], 2);
      check("R3 no verdict before 16th byte", alm_trace, 1'b1);
      send_byte(s_ok[15], 0);
      check("R3 verdict at 16th byte", alm_trace, 1'b0);
   endtask

   task automatic t_restart16;
      send_byte(8'hFF, 0);
      send_byte(8'h01, 0);
      send_byte(8'h02, 0);
      send_byte(8'h03, 0);
      send_byte(8'h04, 0);
      send16(s_ok, 0, 10);
      check("R9 marker restarts short string", alm_trace, 1'b0);
      send16(s_ok, 11, 15);
      check("R9 restarted string evaluates clean", alm_trace, 1'b0);
   endtask

   task automatic t_crc_long_clear;
      send16(s_crc, 0, 15);
      check("R6 crc alarm before mode switch", alm_crc, 1'b1);
      mode_long = 1'b1;
      @(negedge clk);
      @(negedge clk);
      check("R8 crc alarm cleared in long mode", alm_crc, 1'b0);
      check("R4 trace held over mode switch", alm_trace, 1'b1);
   endtask

   task automatic t_long;
      for (int i = 0; i < 64; i++) write_exp(i, l_ok[i]);
      send_byte(8'h0D, 0);
      send_byte(8'h0A, 0);
      send64(l_ok, 0, 63);
      check("R7 long string match", alm_trace, 1'b0);
      check("R8 crc quiet in long mode", alm_crc, 1'b0);
      send64(l_bad, 0, 63);
      check("R7 long string mismatch", alm_trace, 1'b1);
      send64(l_ok, 0, 62);
      check("R7 no verdict before 64th byte", alm_trace, 1'b1);
      send64(l_ok, 63, 63);
      check("R7 verdict at 64th byte", alm_trace, 1'b0);
   endtask

   task automatic t_restart64;
      send64(l_bad, 0, 63);
      check("R7 mismatch before restart", alm_trace, 1'b1);
      send64(l_ok, 0, 9);
      send_byte(8'h0D, 0);
      send_byte(8'h0A, 0);
      send64(l_ok, 0, 63);
      check("R9 early delimiter restarts long string", alm_trace, 1'b0);
   endtask

   initial begin
      for (int i = 1; i < 16; i++) s_ok[i] = 8'h61 + 8'(i);
      s_ok[0] = 8'h80;
      s_ok[0] = {1'b1, ref_crc(s_ok)};
      s_bad = s_ok;
      s_bad[7] = s_ok[7] ^ 8'h01;
      s_crc = s_ok;
      s_crc[0] = s_ok[0] ^ 8'h01;
      for (int i = 0; i < 62; i++) l_ok[i] = 8'h20 + 8'(i);
      l_ok[62] = 8'h0D;
      l_ok[63] = 8'h0A;
      l_bad = l_ok;
      l_bad[20] = l_ok[20] ^ 8'h04;
   end

   initial begin
      rst_n = 1'b0;
      trc_byte = '0; trc_vld = 1'b0; mode_long = 1'b0;
      reg_wr_en = 1'b0; reg_addr = '0; reg_wdata = '0;
      repeat (3) @(negedge clk);
      t_reset;
      rst_n = 1'b1;
      @(negedge clk);
      t_mask;
      t_regs;
      t_match16;
      t_diff16;
      t_crc_only;
      t_window;
      t_restart16;
      t_crc_long_clear;
      t_long;
      t_restart64;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule